// File: doc/BRIEF.md
# Instrument error code queue

This block holds the numeric error codes that a command parser raises, so that a host can fetch them later, oldest first, with an error query. Each code is 7 bits wide, which covers the values 0 to 99. The parser offers a code with a valid strobe. The host's query logic pulses a pop strobe and receives the oldest pending code one cycle later. A not-empty flag is exported so that the status logic can place it in the error summary position of the status byte, which is bit 2 with weight 4.

A mode input selects how long entries are kept. In accumulate mode, entries stay until they are popped, and the queue fills if nobody reads it. In auto-clear mode, every "new program message received" strobe empties the queue. Separately from storage, every offered code is echoed on a report output in the following cycle. A serial port that has no service-request line can therefore report each error as soon as it happens. A synchronous clear input empties the queue in either mode and also drops the sticky overflow flag.

Top module: `err_code_queue`

## Requirements
- R1: After `rst` is asserted, and from the first cycle after it is released, `not_empty_o`, `overflow_o`, `pop_valid_o` and `echo_valid_o` are 0, and `pop_code_o` and `echo_code_o` are 0.
- R2: Popping returns codes in the order in which they were accepted. A `pop_i` pulse raises `pop_valid_o` for one cycle in the next cycle, and `pop_code_o` carries the oldest entry in that same cycle.
- R3: The queue holds `DEPTH` (8) entries. A push offered while 8 entries are held is discarded, even if a pop happens in the same cycle. A discarded push sets `overflow_o` from the next cycle on.
- R4: `overflow_o` stays at 1 until `clr_i` or `rst` is applied. Pops, pushes and `msg_new_i` do not clear it.
- R5: A pop while the queue is empty still gives `pop_valid_o`=1, with `pop_code_o`=0 meaning "no error". It removes nothing, and a later push is popped normally.
- R6: With `mode_accum_i`=1 (accumulate), `msg_new_i` has no effect: `not_empty_o` and the stored entries remain unchanged.
- R7: With `mode_accum_i`=0 (auto-clear), a `msg_new_i` pulse empties the queue, so `not_empty_o` is 0 in the next cycle when no push accompanies the pulse.
- R8: When a flush (`clr_i`, or `msg_new_i` in auto-clear mode) coincides with a push, the flush is applied first. The queue then holds only the new code.
- R9: Every cycle with `push_valid_i`=1 gives `echo_valid_o`=1 and `echo_code_o`=that code in the next cycle, whether or not the code was stored. `echo_code_o` keeps the last echoed code at other times.
- R10: `not_empty_o` is 1 exactly when at least one entry is held, and it is updated in the cycle after the push, pop or flush that changes the count.
- R11: `clr_i` empties the queue in either mode and clears `overflow_o`, both taking effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear: empties the queue and drops overflow |
| mode_accum_i | input | 1 | 1 = accumulate, 0 = auto-clear on new message |
| msg_new_i | input | 1 | New program message received strobe |
| push_valid_i | input | 1 | Code offered by the parser |
| push_code_i | input | 7 | Error code (0 to 99) |
| pop_i | input | 1 | Error query: remove the oldest code |
| pop_valid_o | output | 1 | Pop result valid, one cycle after `pop_i` |
| pop_code_o | output | 7 | Popped code, 0 if the queue was empty |
| not_empty_o | output | 1 | At least one code held (status byte bit 2) |
| overflow_o | output | 1 | Sticky: a push was discarded while full |
| echo_valid_o | output | 1 | Immediate report strobe |
| echo_code_o | output | 7 | Immediately reported code |

## Verification
Every result of this block is due exactly one clock after the stimulus that causes it: the pop result, the echo, the not-empty flag after a push, pop or flush, and the overflow flag after a discarded push. The bench applies inputs on the falling edge and advances its reference model at the rising edge where the design samples those inputs. It then compares every output on the following falling edge. Because the model is compared on every clock, a result that arrives a cycle early or a cycle late is reported as a mismatch in the cycle where it should have appeared.

// File: rtl/errq_pkg.sv
package errq_pkg;

  localparam int ERRQ_CODE_W_DEF = 7;
  localparam int ERRQ_DEPTH_DEF  = 8;

  // Per-cycle decision taken by the controller
  typedef struct packed {
    logic flush;    // queue emptied before anything else this cycle
    logic push_ok;  // offered code is stored
    logic pop_ok;   // oldest entry is removed
    logic drop;     // offered code discarded because the queue is full
  } errq_op_t;

endpackage

// File: rtl/errq_ctrl.sv
module errq_ctrl
  import errq_pkg::*;
#(
  parameter int DEPTH = ERRQ_DEPTH_DEF,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             mode_accum_i,
  input  logic             msg_new_i,
  input  logic             push_valid_i,
  input  logic             pop_i,
  output logic             we_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic             re_o,
  output logic [PTR_W-1:0] raddr_o,
  output logic             not_empty_o,
  output logic             overflow_o,
  output logic             pop_valid_o,
  output logic             pop_hit_o
);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  logic [PTR_W-1:0] wr_base, rd_base, wr_inc, rd_inc, wr_n, rd_n;
  logic [CNT_W-1:0] cnt_base, cnt_n;
  errq_op_t         op;

  // Flush comes first; push and pop then act on the flushed state.
  always_comb begin
    op.flush   = clr_i | (msg_new_i & ~mode_accum_i);
    wr_base    = op.flush ? '0 : wr_q;
    rd_base    = op.flush ? '0 : rd_q;
    cnt_base   = op.flush ? '0 : cnt_q;
    op.pop_ok  = pop_i & (cnt_base != '0);
    op.push_ok = push_valid_i & (cnt_base != CNT_W'(DEPTH));
    op.drop    = push_valid_i & (cnt_base == CNT_W'(DEPTH));
  end

  // Pointer wrap: free for power-of-two depths, explicit compare otherwise
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_inc = wr_base + PTR_W'(1);
      assign rd_inc = rd_base + PTR_W'(1);
    end else begin : g_wrap_cmp
      assign wr_inc = (wr_base == PTR_W'(DEPTH - 1)) ? '0 : wr_base + PTR_W'(1);
      assign rd_inc = (rd_base == PTR_W'(DEPTH - 1)) ? '0 : rd_base + PTR_W'(1);
    end
  endgenerate

  always_comb begin
    wr_n  = op.push_ok ? wr_inc : wr_base;
    rd_n  = op.pop_ok ? rd_inc : rd_base;
    cnt_n = cnt_base + CNT_W'(op.push_ok) - CNT_W'(op.pop_ok);
  end

  assign we_o    = op.push_ok;
  assign waddr_o = wr_base;
  assign re_o    = op.pop_ok;
  assign raddr_o = rd_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q        <= '0;
      rd_q        <= '0;
      cnt_q       <= '0;
      not_empty_o <= 1'b0;
      overflow_o  <= 1'b0;
      pop_valid_o <= 1'b0;
      pop_hit_o   <= 1'b0;
    end else begin
      wr_q        <= wr_n;
      rd_q        <= rd_n;
      cnt_q       <= cnt_n;
      not_empty_o <= (cnt_n != '0);
      overflow_o  <= clr_i ? 1'b0 : (overflow_o | op.drop);
      pop_valid_o <= pop_i;
      pop_hit_o   <= op.pop_ok;
    end
  end

endmodule

// File: rtl/errq_store.sv
module errq_store #(
  parameter int DEPTH  = 8,
  parameter int CODE_W = 7,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [CODE_W-1:0] rdata_o
);

  // Simple dual-port array with registered read, no reset: maps to block RAM
  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/errq_echo.sv
module errq_echo #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid_i,
  input  logic [CODE_W-1:0] push_code_i,
  output logic              echo_valid_o,
  output logic [CODE_W-1:0] echo_code_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      echo_valid_o <= 1'b0;
      echo_code_o  <= '0;
    end else begin
      echo_valid_o <= push_valid_i;
      if (push_valid_i) echo_code_o <= push_code_i;
    end
  end

endmodule

// File: rtl/err_code_queue.sv
module err_code_queue
  import errq_pkg::*;
#(
  parameter int CODE_W = ERRQ_CODE_W_DEF,
  parameter int DEPTH  = ERRQ_DEPTH_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              mode_accum_i,
  input  logic              msg_new_i,
  input  logic              push_valid_i,
  input  logic [CODE_W-1:0] push_code_i,
  input  logic              pop_i,
  output logic              pop_valid_o,
  output logic [CODE_W-1:0] pop_code_o,
  output logic              not_empty_o,
  output logic              overflow_o,
  output logic              echo_valid_o,
  output logic [CODE_W-1:0] echo_code_o
);

  localparam int PTR_W = $clog2(DEPTH);

  logic             we, re, pop_hit;
  logic [PTR_W-1:0] waddr, raddr;
  logic [CODE_W-1:0] rdata;

  errq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .clr_i        (clr_i),
    .mode_accum_i (mode_accum_i),
    .msg_new_i    (msg_new_i),
    .push_valid_i (push_valid_i),
    .pop_i        (pop_i),
    .we_o         (we),
    .waddr_o      (waddr),
    .re_o         (re),
    .raddr_o      (raddr),
    .not_empty_o  (not_empty_o),
    .overflow_o   (overflow_o),
    .pop_valid_o  (pop_valid_o),
    .pop_hit_o    (pop_hit)
  );

  errq_store #(.DEPTH(DEPTH), .CODE_W(CODE_W)) store_i (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (push_code_i),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  errq_echo #(.CODE_W(CODE_W)) echo_i (
    .clk          (clk),
    .rst          (rst),
    .push_valid_i (push_valid_i),
    .push_code_i  (push_code_i),
    .echo_valid_o (echo_valid_o),
    .echo_code_o  (echo_code_o)
  );

  // An empty pop reports code 0 ("no error")
  assign pop_code_o = pop_hit ? rdata : '0;

endmodule

// File: rtl/errq_chk.sv
module errq_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_i,
  input logic              mode_accum_i,
  input logic              msg_new_i,
  input logic              push_valid_i,
  input logic [CODE_W-1:0] push_code_i,
  input logic              pop_i,
  input logic              pop_valid_o,
  input logic [CODE_W-1:0] pop_code_o,
  input logic              not_empty_o,
  input logic              overflow_o,
  input logic              echo_valid_o,
  input logic [CODE_W-1:0] echo_code_o
);

  // R1
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!not_empty_o && !overflow_o && !pop_valid_o && !echo_valid_o));

  // R2
  p_pop_valid_r2: assert property (@(posedge clk) disable iff (rst)
    pop_i |=> pop_valid_o);

  // R4
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && !clr_i) |=> overflow_o);

  // R5
  p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !not_empty_o) |=> (pop_code_o == '0));

  // R7
  p_msg_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (!mode_accum_i && msg_new_i && !push_valid_i) |=> !not_empty_o);

  // R8
  p_flush_push_r8: assert property (@(posedge clk) disable iff (rst)
    ((clr_i || (msg_new_i && !mode_accum_i)) && push_valid_i) |=> not_empty_o);

  // R9
  p_echo_r9: assert property (@(posedge clk) disable iff (rst)
    push_valid_i |=> (echo_valid_o && echo_code_o == $past(push_code_i)));

  // R10
  p_push_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
    (push_valid_i && !pop_i) |=> not_empty_o);

  // R11
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !push_valid_i) |=> (!not_empty_o && !overflow_o));

endmodule

bind err_code_queue errq_chk #(.CODE_W(CODE_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .clr_i        (clr_i),
  .mode_accum_i (mode_accum_i),
  .msg_new_i    (msg_new_i),
  .push_valid_i (push_valid_i),
  .push_code_i  (push_code_i),
  .pop_i        (pop_i),
  .pop_valid_o  (pop_valid_o),
  .pop_code_o   (pop_code_o),
  .not_empty_o  (not_empty_o),
  .overflow_o   (overflow_o),
  .echo_valid_o (echo_valid_o),
  .echo_code_o  (echo_code_o)
);

// File: tb/err_code_queue_tb_top.sv
`timescale 1ns/1ps
module err_code_queue_tb_top;

  localparam int CW = 7;
  localparam int DP = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1, clr = 1'b0, mode = 1'b1, msg = 1'b0;
  logic          pv = 1'b0, pop = 1'b0;
  logic [CW-1:0] pc = '0;
  logic          pop_valid, not_empty, overflow, echo_valid;
  logic [CW-1:0] pop_code, echo_code;

  err_code_queue #(.CODE_W(CW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .clr_i(clr), .mode_accum_i(mode), .msg_new_i(msg),
    .push_valid_i(pv), .push_code_i(pc), .pop_i(pop),
    .pop_valid_o(pop_valid), .pop_code_o(pop_code), .not_empty_o(not_empty),
    .overflow_o(overflow), .echo_valid_o(echo_valid), .echo_code_o(echo_code)
  );

  int checks = 0, failures = 0, cycles = 0;

  // reference model state
  int m_q[$];
  bit m_ovf, m_popv, m_echov;
  int m_popc, m_echoc;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic model_step();
    bit full;
    if (rst) begin
      m_q.delete(); m_ovf = 0; m_popv = 0; m_echov = 0; m_popc = 0; m_echoc = 0;
      return;
    end
    if (clr || (msg && !mode)) m_q.delete();
    if (clr) m_ovf = 0;
    full = (m_q.size() >= DP);
    m_popv = pop; m_popc = 0;
    if (pop && m_q.size() > 0) m_popc = m_q.pop_front();
    if (pv) begin
      if (!full) m_q.push_back(int'(pc)); else m_ovf = 1;
    end
    m_echov = pv;
    if (pv) m_echoc = int'(pc);
  endtask

  // one clock: inputs already set at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cycles++;
    chk(pop_valid == m_popv, "R2 pop_valid", pop_valid, m_popv);
    if (m_popv) chk(int'(pop_code) == m_popc, "R2 pop_code", pop_code, m_popc);
    chk(not_empty == (m_q.size() > 0), "R10 not_empty", not_empty, m_q.size() > 0);
    chk(overflow == m_ovf, "R3 overflow", overflow, m_ovf);
    chk(echo_valid == m_echov, "R9 echo_valid", echo_valid, m_echov);
    chk(int'(echo_code) == m_echoc, "R9 echo_code", echo_code, m_echoc);
  endtask

  task automatic idle();
    clr = 0; msg = 0; pv = 0; pop = 0;
  endtask

  task automatic push(input int code);
    idle(); pv = 1; pc = CW'(code); cyc(); idle();
  endtask

  task automatic pop1();
    idle(); pop = 1; cyc(); idle();
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1; idle(); cyc(); cyc();
    rst = 0; cyc();
    // R1: reset state
    chk(!not_empty && !overflow && !pop_valid && !echo_valid && pop_code == 0 && echo_code == 0,
        "R1 reset state", {not_empty, overflow, pop_valid, echo_valid}, 0);

    // R2 order in accumulate mode, R5 empty pop
    mode = 1;
    push(5); push(42); push(99);
    pop1(); chk(pop_code == 5, "R2 first", pop_code, 5);
    pop1(); chk(pop_code == 42, "R2 second", pop_code, 42);
    pop1(); chk(pop_code == 99, "R2 third", pop_code, 99);
    pop1(); chk(pop_valid && pop_code == 0, "R5 empty pop", pop_code, 0);
    push(17); pop1(); chk(pop_code == 17, "R5 after empty pop", pop_code, 17);

    // R3 fill to depth, discarded ninth push, R9 echo of the discarded code
    for (int i = 0; i < DP; i++) push(10 + i);
    chk(!overflow, "R3 full no overflow", overflow, 0);
    idle(); pv = 1; pc = 7'd77; pop = 1; cyc(); idle();
    chk(overflow, "R3 push while full dropped", overflow, 1);
    chk(echo_valid && echo_code == 77, "R9 echo of dropped code", echo_code, 77);
    for (int i = 1; i < DP; i++) begin
      pop1(); chk(pop_code == 10 + i, "R3 order after drop", pop_code, 10 + i);
    end
    pop1(); chk(pop_code == 0, "R3 dropped code never stored", pop_code, 0);

    // R6 message ignored in accumulate mode, R4 overflow survives it
    push(3); push(4);
    idle(); msg = 1; cyc(); idle();
    chk(not_empty, "R6 msg no effect", not_empty, 1);
    chk(overflow, "R4 overflow kept over msg", overflow, 1);
    pop1(); chk(pop_code == 3, "R6 entries intact", pop_code, 3);

    // R11 clear empties and drops overflow
    idle(); clr = 1; cyc(); idle();
    chk(!not_empty && !overflow, "R11 clear", {not_empty, overflow}, 0);

    // R7 auto-clear flush, R8 flush with push
    mode = 0;
    push(21); push(22); push(23);
    idle(); msg = 1; cyc(); idle();
    chk(!not_empty, "R7 msg flush", not_empty, 0);
    push(30);
    idle(); msg = 1; pv = 1; pc = 7'd31; cyc(); idle();
    chk(not_empty, "R8 new code kept", not_empty, 1);
    pop1(); chk(pop_code == 31, "R8 only new code", pop_code, 31);
    pop1(); chk(pop_code == 0, "R8 nothing else", pop_code, 0);
    idle(); clr = 1; pv = 1; pc = 7'd44; mode = 1; cyc(); idle();
    pop1(); chk(pop_code == 44, "R8 clear with push", pop_code, 44);

    // mixed stress against the model
    for (int n = 0; n < 2000; n++) begin
      idle();
      pv   = ($urandom_range(0, 99) < 55);
      pc   = CW'($urandom_range(0, 99));
      pop  = ($urandom_range(0, 99) < 40);
      msg  = ($urandom_range(0, 99) < 4);
      clr  = ($urandom_range(0, 99) < 1);
      if ($urandom_range(0, 99) < 2) mode = ~mode;
      cyc();
    end
    idle(); cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule